// File: doc/BRIEF.md
# Host Bus Slave Port with Intel and Motorola Cycle Decoding

This block sits between an external processor bus and the register and memory space of a larger chip. The same set of bus pins can carry three styles of cycle: a Motorola-style cycle on separate address lines, a Motorola-style cycle with address and data sharing the low data byte, and an Intel-style cycle on the shared bus. The block turns each of these into one internal read strobe or one internal write strobe, together with an address and write data. It returns read data on a 16-bit bus with a separate output enable, and it drives an acknowledge line that the host can wait on.

All bus inputs are brought into the core clock domain through a synchronizer. A static select pin chooses the shared-bus or separate-address wiring. On the shared bus, the level of the read/data-strobe pin at the moment the address latch strobe falls decides whether the cycle is Intel or Motorola style: that pin idles high for Intel and low for Motorola. The host is assumed to hold the address and write data stable for a few core clocks past each strobe edge, because the synchronized strobes arrive some cycles after the raw pins change.

Top module: `host_bus_port`

## Requirements
- R1: While reset is asserted and on the first clock after it, data_oe, dta_oe, reg_we and reg_re are all 0.
- R2: When mux_sel is 1, the cycle address is the value on data_in[7:0] at the falling edge of as_ale, and the addr pins are ignored.
- R3: When mux_sel is 0, the cycle address comes from the addr pins and any activity on as_ale has no effect on it.
- R4: In shared-bus Motorola style (ds_rd low when as_ale falls), a cycle is active while cs_n is 0 and ds_rd is 1. rw_wr = 1 selects a read and rw_wr = 0 selects a write.
- R5: In separate-address style (mux_sel = 0), a cycle is active while cs_n is 0 and ds_rd is 0. rw_wr sets the direction as in R4.
- R6: In shared-bus Intel style (ds_rd high when as_ale falls), ds_rd low is a read strobe and rw_wr low is a write strobe, both qualified by cs_n = 0.
- R7: A write produces exactly one reg_we pulse, issued after the qualified strobe deasserts. It carries the cycle address on reg_addr and the last data_in value seen while the strobe was active on reg_wdata.
- R8: A read produces exactly one reg_re pulse at the start of the cycle. While the strobe stays active, data_oe is 1 and data_out shows the reg_rdata value returned for the cycle address.
- R9: data_oe is 0 whenever the synchronized cs_n is high (from the following clock) and whenever reset is asserted.
- R10: Once the transfer is complete and while the strobe is still active, dta is driven low (dta_oe = 1, dta = 0). After the strobe ends, dta is driven high for exactly ACK_HI_CYCLES clocks (default 2) and then released (dta_oe = 0).
- R11: Strobe activity while cs_n is high produces no reg_we, no reg_re and no data_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_sel | input | 1 | 1: address and data share the low data byte; 0: separate address pins |
| cs_n | input | 1 | Active-low chip select |
| as_ale | input | 1 | Address strobe / address latch enable (shared-bus styles only) |
| ds_rd | input | 1 | Motorola data strobe or Intel active-low read |
| rw_wr | input | 1 | Motorola read/write (1 = read) or Intel active-low write |
| addr | input | AW (8) | Separate address pins |
| data_in | input | DW (16) | Bus data toward the block; low byte also carries the shared address |
| data_out | output | DW (16) | Read data toward the bus |
| data_oe | output | 1 | Drive enable for data_out |
| dta | output | 1 | Transfer acknowledge level |
| dta_oe | output | 1 | Drive enable for dta |
| reg_addr | output | AW (8) | Address of the current internal access |
| reg_wdata | output | DW (16) | Write data for the internal access |
| reg_we | output | 1 | One-clock internal write strobe |
| reg_re | output | 1 | One-clock internal read strobe |
| reg_rdata | input | DW (16) | Read data returned by the register space for reg_addr |

## Verification
The hardest case to reach is a change of bus style between consecutive cycles on the shared bus. The style is not a pin. It is inferred from the idle level of ds_rd at the instant the address latch strobe falls, so a wrong inference shows up only as a missing or spurious strobe one cycle later. The vector table therefore alternates separate-address, Motorola shared and Intel shared cycles back to back, each with its own idle levels before the latch pulse. Directed tests then toggle as_ale during a separate-address write, put a misleading value on the addr pins during a shared-bus write, strobe with chip select high, and assert reset in the middle of a read.

// File: rtl/hbp_pkg.sv
// Shared types for the host bus port.
// Assumes: a single core clock domain after input synchronization.
package hbp_pkg;

    // Bus cycle style as inferred from mux_sel and the latch-time strobe level.
    typedef enum logic [1:0] {
        STYLE_MOT_SEP   = 2'd0,
        STYLE_MOT_MUX   = 2'd1,
        STYLE_INTEL_MUX = 2'd2
    } bus_style_e;

    // Acknowledge driver phases.
    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_LOW  = 2'd1,
        ACK_HIGH = 2'd2
    } ack_state_e;

    // Bundle of host control pins that pass through the synchronizer.
    typedef struct packed {
        logic im;
        logic cs_n;
        logic as_ale;
        logic ds_rd;
        logic rw_wr;
    } bus_pins_t;

    localparam int PIN_W = $bits(bus_pins_t);

endpackage

// File: rtl/hbp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; bits may settle on different cycles.
module hbp_sync #(
    parameter int               WIDTH   = 5,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/hbp_front.sv
// Bus front end: infers the cycle style, qualifies the strobe, latches the address.
// Assumes: synchronized control pins; the raw address source is still stable
// when the synchronized latch or strobe edge is seen.
module hbp_front
    import hbp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_pins_t     s,
    input  logic [AW-1:0] addr_pins,
    input  logic [AW-1:0] bus_lo,
    output logic          act,
    output logic          is_wr,
    output logic [AW-1:0] cyc_addr
);

    logic       as_q;
    logic       intel_q;
    logic       act_d;
    logic       as_fall;
    logic       act_rise;
    bus_style_e style;

    assign as_fall  = as_q & ~s.as_ale;
    assign act_rise = act & ~act_d;

    // Style follows mux_sel, then the strobe level remembered at latch time.
    always_comb begin
        if (!s.im)        style = STYLE_MOT_SEP;
        else if (intel_q) style = STYLE_INTEL_MUX;
        else              style = STYLE_MOT_MUX;
    end

    // Qualified strobe per style; chip select gates every style.
    always_comb begin
        unique case (style)
            STYLE_MOT_SEP:   act = ~s.cs_n & ~s.ds_rd;
            STYLE_MOT_MUX:   act = ~s.cs_n &  s.ds_rd;
            STYLE_INTEL_MUX: act = ~s.cs_n & (~s.ds_rd | ~s.rw_wr);
            default:         act = 1'b0;
        endcase
    end

    // Motorola R/W low and Intel WR low both mean write.
    assign is_wr = ~s.rw_wr;

    // Edge history for the latch strobe and the qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q  <= 1'b0;
            act_d <= 1'b0;
        end else begin
            as_q  <= s.as_ale;
            act_d <= act;
        end
    end

    // Style inference: ds_rd idles high on an Intel bus and low on Motorola.
    always_ff @(posedge clk) begin
        if (!rst_n)                intel_q <= 1'b0;
        else if (s.im && as_fall)  intel_q <= s.ds_rd;
    end

    // Address capture: shared bus at latch fall, separate pins at strobe start.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cyc_addr <= '0;
        else if (s.im && as_fall)          cyc_addr <= bus_lo;
        else if (!s.im && act_rise)        cyc_addr <= addr_pins;
    end

endmodule

// File: rtl/hbp_xfer.sv
// Transfer engine: issues the internal read/write strobes and drives read data.
// Assumes: act is the qualified strobe; write data is stable while act is high.
module hbp_xfer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          is_wr,
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_we,
    output logic          reg_re,
    output logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          done
);

    logic          act_q;
    logic          cyc_wr;
    logic          rd_valid;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] wdata_q;
    logic          start;
    logic          finish;

    assign start  = act & ~act_q;
    assign finish = ~act & act_q;

    // Cycle bookkeeping: direction is frozen at strobe start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cyc_wr <= 1'b0;
        end else begin
            act_q <= act;
            if (start) cyc_wr <= is_wr;
        end
    end

    // Read path: one strobe at start, capture returned data on the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_re   <= 1'b0;
            rdata_q  <= '0;
            rd_valid <= 1'b0;
        end else begin
            reg_re <= start & ~is_wr;
            if (reg_re) begin
                rdata_q  <= reg_rdata;
                rd_valid <= 1'b1;
            end else if (!act) begin
                rd_valid <= 1'b0;
            end
        end
    end

    // Write path: track bus data during the strobe, commit once it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            reg_we  <= 1'b0;
        end else begin
            if (act && is_wr) wdata_q <= data_in;
            reg_we <= finish & cyc_wr;
        end
    end

    // Bus drive and completion flag, both registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            data_oe <= act & act_q & ~cyc_wr & rd_valid;
            done    <= act & act_q & (cyc_wr | rd_valid);
        end
    end

    assign reg_wdata = wdata_q;
    assign data_out  = rdata_q;

endmodule

// File: rtl/hbp_ack.sv
// Acknowledge driver: low while complete, high for a fixed time after, then released.
// Assumes: done only rises while act is high.
module hbp_ack
    import hbp_pkg::*;
#(
    parameter int HI_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic done,
    output logic dta,
    output logic dta_oe
);

    localparam int CW = (HI_CYCLES > 1) ? $clog2(HI_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(HI_CYCLES - 1);

    ack_state_e    state;
    logic [CW-1:0] cnt;

    // Phase sequencing and high-drive timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACK_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ACK_IDLE: if (done) state <= ACK_LOW;
                ACK_LOW: begin
                    if (!act) begin
                        state <= ACK_HIGH;
                        cnt   <= CNT_LOAD;
                    end
                end
                ACK_HIGH: begin
                    if (cnt == '0) state <= ACK_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ACK_IDLE;
            endcase
        end
    end

    assign dta    = (state == ACK_HIGH);
    assign dta_oe = (state != ACK_IDLE);

endmodule

// File: rtl/host_bus_port.sv
// Top level of the host bus port: synchronizer, front end, transfer engine,
// acknowledge driver. Assumes the host holds address and data a few core
// clocks beyond each strobe edge so the synchronized edges see them.
module host_bus_port
    import hbp_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int ACK_HI_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_sel,
    input  logic          cs_n,
    input  logic          as_ale,
    input  logic          ds_rd,
    input  logic          rw_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          dta,
    output logic          dta_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    localparam logic [PIN_W-1:0] PIN_RST = 5'b01011;

    bus_pins_t raw_pins;
    bus_pins_t s_pins;
    logic      s_cs_n;
    logic      act;
    logic      is_wr;
    logic      done;

    assign raw_pins = '{im: mux_sel, cs_n: cs_n, as_ale: as_ale, ds_rd: ds_rd, rw_wr: rw_wr};
    assign s_cs_n   = s_pins.cs_n;

    hbp_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (s_pins)
    );

    hbp_front #(
        .AW(AW)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .s        (s_pins),
        .addr_pins(addr),
        .bus_lo   (data_in[AW-1:0]),
        .act      (act),
        .is_wr    (is_wr),
        .cyc_addr (reg_addr)
    );

    hbp_xfer #(
        .DW(DW)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .is_wr    (is_wr),
        .data_in  (data_in),
        .reg_rdata(reg_rdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_wdata(reg_wdata),
        .data_out (data_out),
        .data_oe  (data_oe),
        .done     (done)
    );

    hbp_ack #(
        .HI_CYCLES(ACK_HI_CYCLES)
    ) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .done  (done),
        .dta   (dta),
        .dta_oe(dta_oe)
    );

endmodule

// File: rtl/hbp_checker.sv
// Protocol checker for host_bus_port, attached with bind.
// Assumes: synchronous active-low reset; act and s_cs_n are top-level nets.
module hbp_checker (
    input logic clk,
    input logic rst_n,
    input logic s_cs_n,
    input logic act,
    input logic reg_we,
    input logic reg_re,
    input logic data_oe,
    input logic dta,
    input logic dta_oe
);

    assert_oe_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> !data_oe);

    assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_we_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !$past(act));

    assert_re_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    assert_re_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> $past(act));

    assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    assert_ack_release_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dta_oe) |-> $past(dta));

    assert_ack_low_in_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dta_oe && !dta) |-> $past(act));

endmodule

bind host_bus_port hbp_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_cs_n (s_cs_n),
    .act    (act),
    .reg_we (reg_we),
    .reg_re (reg_re),
    .data_oe(data_oe),
    .dta    (dta),
    .dta_oe (dta_oe)
);

// File: tb/host_bus_port_tb.sv
module host_bus_port_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int HI = 2;
    localparam int NV = 8;

    // Vector: {style[1:0], write, addr[7:0], data[15:0]}; style 0 sep, 1 Motorola shared, 2 Intel shared.
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b1, 8'h12, 16'hBEEF},
        {2'd0, 1'b0, 8'h12, 16'h0000},
        {2'd1, 1'b1, 8'h3C, 16'h1234},
        {2'd1, 1'b0, 8'h3C, 16'h0000},
        {2'd2, 1'b1, 8'hC7, 16'hA55A},
        {2'd2, 1'b0, 8'h81, 16'h0000},
        {2'd1, 1'b0, 8'hFF, 16'h0000},
        {2'd0, 1'b1, 8'h00, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mux_sel = 1'b0;
    logic          cs_n = 1'b1;
    logic          as_ale = 1'b0;
    logic          ds_rd = 1'b1;
    logic          rw_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic          dta;
    logic          dta_oe;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_we;
    logic          reg_re;
    logic [DW-1:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int hi_cnt = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;
    logic [AW-1:0] last_raddr = '0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    // Register-space model: read data is a fixed function of the address.
    function automatic logic [DW-1:0] rmodel(input logic [AW-1:0] a);
        return {a ^ 8'hA5, a};
    endfunction
    assign reg_rdata = rmodel(reg_addr);

    host_bus_port #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .ACK_HI_CYCLES(HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .cs_n(cs_n), .as_ale(as_ale),
        .ds_rd(ds_rd), .rw_wr(rw_wr), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .dta(dta), .dta_oe(dta_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // Port monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (reg_we) begin we_cnt++; last_waddr = reg_addr; last_wdata = reg_wdata; end
        if (reg_re) begin re_cnt++; last_raddr = reg_addr; end
        if (dta_oe && dta) hi_cnt++;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus cycle of the given style; checks strobes, data and acknowledge.
    task automatic bus_cycle(input int style, input bit wr, input logic [7:0] a,
                             input logic [15:0] d, input bit cs_on, input bit poke_as);
        int we0, re0;
        @(negedge clk);
        cs_n = 1'b1;
        rw_wr = 1'b1;
        if (style == 0) begin
            mux_sel = 1'b0; as_ale = 1'b0; ds_rd = 1'b1; addr = a;
            data_in = wr ? d : 16'h0000;
            wait_n(4);
        end else begin
            mux_sel = 1'b1;
            ds_rd   = (style == 2);
            addr    = ~a;
            data_in = {8'h00, a};
            wait_n(4);
            as_ale = 1'b1; wait_n(4);
            as_ale = 1'b0; wait_n(6);
            data_in = wr ? d : 16'h0000;
        end
        we0 = we_cnt; re0 = re_cnt; hi_cnt = 0;
        if (style != 2) rw_wr = ~wr;
        cs_n = ~cs_on;
        if (style == 0)      ds_rd = 1'b0;
        else if (style == 1) ds_rd = 1'b1;
        else if (wr)         rw_wr = 1'b0;
        else                 ds_rd = 1'b0;
        wait_n(5);
        if (poke_as) begin as_ale = 1'b1; data_in[7:0] = ~a; wait_n(3); as_ale = 1'b0; data_in = d; end
        wait_n(5);
        if (!cs_on) begin
            check("R11 data_oe with cs_n high", data_oe, 0);
        end else if (!wr) begin
            check("R8 data_oe during read", data_oe, 1);
            check("R8 data_out", data_out, rmodel(a));
            check("R10 ack low during read", {dta_oe, dta}, 2'b10);
        end else begin
            check("R10 ack low during write", {dta_oe, dta}, 2'b10);
        end
        if (style == 0)      ds_rd = 1'b1;
        else if (style == 1) ds_rd = 1'b0;
        else begin ds_rd = 1'b1; rw_wr = 1'b1; end
        cs_n = 1'b1;
        wait_n(12);
        if (!cs_on) begin
            check("R11 no reg_we", we_cnt - we0, 0);
            check("R11 no reg_re", re_cnt - re0, 0);
            check("R11 no ack", hi_cnt, 0);
        end else if (wr) begin
            check("R7 one reg_we", we_cnt - we0, 1);
            check("R7 no reg_re on write", re_cnt - re0, 0);
            check("R7 write address", last_waddr, a);
            check("R7 write data", last_wdata, d);
            check("R10 ack high cycles", hi_cnt, HI);
        end else begin
            check("R8 one reg_re", re_cnt - re0, 1);
            check("R8 no reg_we on read", we_cnt - we0, 0);
            check("R8 read address", last_raddr, a);
            check("R10 ack high cycles", hi_cnt, HI);
        end
        check("R10 ack released", dta_oe, 0);
        check("R9 data_oe after cs_n high", data_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R1: outputs quiet in reset and just after it.
        check("R1 data_oe in reset", data_oe, 0);
        check("R1 dta_oe in reset", dta_oe, 0);
        check("R1 strobes in reset", {reg_we, reg_re}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 quiet after reset", {data_oe, dta_oe, reg_we, reg_re}, 4'b0000);
        wait_n(4);

        // Table walk: R2, R4, R5, R6 across style changes.
        for (int i = 0; i < NV; i++) begin
            bus_cycle(int'(VEC[i][26:25]), VEC[i][24], VEC[i][23:16], VEC[i][15:0], 1'b1, 1'b0);
        end

        // R3: as_ale toggled with a different low byte during a separate-address write.
        bus_cycle(0, 1'b1, 8'h5E, 16'h7788, 1'b1, 1'b1);
        bus_cycle(0, 1'b0, 8'h5E, 16'h0000, 1'b1, 1'b0);

        // R2: shared-bus write while addr pins hold the complement.
        bus_cycle(1, 1'b1, 8'h69, 16'hC001, 1'b1, 1'b0);
        bus_cycle(2, 1'b0, 8'h69, 16'h0000, 1'b1, 1'b0);

        // R11: strobes with chip select high in two styles.
        bus_cycle(0, 1'b1, 8'h44, 16'h1111, 1'b0, 1'b0);
        bus_cycle(2, 1'b0, 8'h45, 16'h0000, 1'b0, 1'b0);

        // R9 / R1: reset in the middle of a read drops the data drive.
        @(negedge clk);
        mux_sel = 1'b0; addr = 8'h2A; rw_wr = 1'b1; as_ale = 1'b0;
        cs_n = 1'b0; ds_rd = 1'b0;
        wait_n(10);
        check("R9 read driving before reset", data_oe, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 data_oe cleared by reset", data_oe, 0);
        check("R1 dta_oe cleared by reset", dta_oe, 0);
        cs_n = 1'b1; ds_rd = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(6);
        check("R1 quiet after second reset", {data_oe, dta_oe}, 2'b00);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule